// File: doc/BRIEF.md
# Condition Flags and Branch Resolver

This block holds the three condition flags of a 16-bit pipelined RISC core and decides, in the same cycle a control operation is presented, whether the program counter is redirected and where it goes. It takes two independent input groups each cycle. The first comes from the execute stage: an ALU operation class with the result word and carry-out. The second is a control operation class: a conditional or unconditional jump carrying the value of its destination register, a software interrupt with a vector selector and the two instruction-memory words that form the vector, or a return-from-interrupt carrying the flags popped from the stack.

Each ALU class rewrites only the flags it owns. A conditional jump tests the registered flags, redirects when the tested flag is set, and clears that flag. A software interrupt exposes the current flags so the core can push them, and a return-from-interrupt loads the popped value back. The ALU datapath, the stack and fetch are outside the block. Its branch outputs are combinational, and its flags change on the following clock edge.

Top module: `cfb_unit`

## Requirements
- R1: After reset, the flags read 000, and br_taken, br_target and int_save_flags read zero.
- R2: The flag word places Zero at bit 0, Negative at bit 1 and Carry at bit 2. An arithmetic (alu_cls 1) or shift (alu_cls 3) operation sets Z to (result == 0), N to the result's top bit and C to alu_cout, visible after the next clock edge.
- R3: A logical operation (alu_cls 2) updates Z and N as in R2 and leaves C unchanged.
- R4: SETC (alu_cls 4) sets C to 1 and leaves Z and N unchanged.
- R5: A conditional jump tests the registered flags: JZ (ctl_cls 1) tests Z, JN (ctl_cls 2) tests N and JC (ctl_cls 3) tests C. When the tested flag is 1, br_taken is 1 in the same cycle, br_target is jmp_reg zero-extended to the PC width, and after the edge the tested flag is 0 while the other flags are unchanged.
- R6: A conditional jump whose tested flag is 0 drives br_taken 0 and br_target 0, and changes no flag.
- R7: JMP (ctl_cls 4) always drives br_taken 1 with br_target equal to jmp_reg zero-extended, and changes no flag.
- R8: INT (ctl_cls 5) drives br_taken 1. int_vec_addr is 6 when int_sel is 0 and 8 when int_sel is 1. br_target is the low PC-width bits of {vec_hi, vec_lo}, where vec_hi is the word at int_vec_addr and vec_lo is the word after it. int_save_flags equals the current flags, and the flags are unchanged. Outside INT, int_save_flags is 0.
- R9: RTI (ctl_cls 6) loads saved_flags into the flags at the next edge. This overrides any ALU update in the same cycle, and RTI drives br_taken 0.
- R10: When a taken conditional jump and an ALU update of the tested flag occur in the same cycle, the flag ends at 0. The other flags take the ALU update.
- R11: alu_cls 0, 5, 6 and 7 and ctl_cls 0 and 7 change no flag and drive br_taken 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_cls | input | 3 | ALU operation class: 0 none, 1 arithmetic, 2 logical, 3 shift, 4 SETC |
| alu_res | input | DATA_W | ALU result word |
| alu_cout | input | 1 | ALU carry-out |
| ctl_cls | input | 3 | Control class: 0 none, 1 JZ, 2 JN, 3 JC, 4 JMP, 5 INT, 6 RTI |
| jmp_reg | input | DATA_W | Value of the jump destination register |
| int_sel | input | 1 | Interrupt vector selector (index 0 or 2) |
| vec_hi | input | DATA_W | Instruction word read at int_vec_addr |
| vec_lo | input | DATA_W | Instruction word read at int_vec_addr + 1 |
| saved_flags | input | 3 | Flags popped from the stack for RTI |
| flags | output | 3 | Condition flags {C, N, Z} |
| br_taken | output | 1 | PC redirect this cycle |
| br_target | output | PC_W | Redirect address, zero when not taken |
| int_vec_addr | output | IMEM_AW | Address of the first vector word |
| int_save_flags | output | 3 | Flags to push on INT, zero otherwise |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 20-bit PC, a 20-bit instruction address and a vector base of 6. A PC wider than the register word but narrower than two words puts both zero-extension of jump targets and truncation of the 32-bit interrupt vector within reach. A 16-bit result lets the sign-bit and all-zero corners be hit directly. Flags that ALU results cannot produce together, such as Z and N both set, are reached by loading them through RTI. Same-cycle collisions of jumps, SETC and RTI with ALU updates are driven on purpose.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  localparam int FLAG_W = 3;
  localparam int FZ     = 0;
  localparam int FN     = 1;
  localparam int FC     = 2;

  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [2:0] {
    ALU_NONE  = 3'd0,
    ALU_ARITH = 3'd1,
    ALU_LOGIC = 3'd2,
    ALU_SHIFT = 3'd3,
    ALU_SETC  = 3'd4
  } alu_cls_e;

  typedef enum logic [2:0] {
    CTL_NONE = 3'd0,
    CTL_JZ   = 3'd1,
    CTL_JN   = 3'd2,
    CTL_JC   = 3'd3,
    CTL_JMP  = 3'd4,
    CTL_INT  = 3'd5,
    CTL_RTI  = 3'd6
  } ctl_cls_e;

  // per-flag write request: mask selects the bits, val carries their values
  typedef struct packed {
    flags_t mask;
    flags_t val;
  } flag_upd_t;

endpackage

// File: rtl/cfb_alu_flags.sv
module cfb_alu_flags
  import cfb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        cls_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  output flag_upd_t         upd_o
);

  logic res_zero;
  logic res_neg;

  assign res_zero = (res_i == '0);
  assign res_neg  = res_i[DATA_W-1];

  always_comb begin
    upd_o = '0;
    case (alu_cls_e'(cls_i))
      ALU_ARITH, ALU_SHIFT: begin
        upd_o.mask      = '1;
        upd_o.val[FZ]   = res_zero;
        upd_o.val[FN]   = res_neg;
        upd_o.val[FC]   = cout_i;
      end
      ALU_LOGIC: begin
        upd_o.mask[FZ]  = 1'b1;
        upd_o.mask[FN]  = 1'b1;
        upd_o.val[FZ]   = res_zero;
        upd_o.val[FN]   = res_neg;
      end
      ALU_SETC: begin
        upd_o.mask[FC]  = 1'b1;
        upd_o.val[FC]   = 1'b1;
      end
      default: upd_o = '0;
    endcase
  end

endmodule

// File: rtl/cfb_branch.sv
module cfb_branch
  import cfb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 20,
  parameter int IMEM_AW  = 20,
  parameter int VEC_BASE = 6
) (
  input  logic [2:0]         cls_i,
  input  flags_t             flags_i,
  input  logic [DATA_W-1:0]  reg_i,
  input  logic               int_sel_i,
  input  logic [DATA_W-1:0]  vec_hi_i,
  input  logic [DATA_W-1:0]  vec_lo_i,
  output logic               taken_o,
  output logic [PC_W-1:0]    target_o,
  output flags_t             clr_o,
  output logic               restore_o,
  output logic               int_o,
  output logic [IMEM_AW-1:0] vec_addr_o
);

  localparam int VEC_W    = 2 * DATA_W;
  localparam int REG_CP   = (PC_W < DATA_W) ? PC_W : DATA_W;
  localparam int VEC_CP   = (PC_W < VEC_W)  ? PC_W : VEC_W;
  localparam int IDX_STEP = 2;

  logic [PC_W-1:0]  reg_pc;
  logic [PC_W-1:0]  vec_pc;
  logic [VEC_W-1:0] vec_cat;

  assign vec_cat = {vec_hi_i, vec_lo_i};

  assign reg_pc[REG_CP-1:0] = reg_i[REG_CP-1:0];
  generate
    if (PC_W > REG_CP) begin : g_reg_pad
      assign reg_pc[PC_W-1:REG_CP] = '0;
    end
  endgenerate

  assign vec_pc[VEC_CP-1:0] = vec_cat[VEC_CP-1:0];
  generate
    if (PC_W > VEC_CP) begin : g_vec_pad
      assign vec_pc[PC_W-1:VEC_CP] = '0;
    end
  endgenerate

  assign vec_addr_o = IMEM_AW'(VEC_BASE) + (int_sel_i ? IMEM_AW'(IDX_STEP) : '0);

  always_comb begin
    taken_o   = 1'b0;
    target_o  = '0;
    clr_o     = '0;
    restore_o = 1'b0;
    int_o     = 1'b0;
    case (ctl_cls_e'(cls_i))
      CTL_JZ: if (flags_i[FZ]) begin
        taken_o   = 1'b1;
        target_o  = reg_pc;
        clr_o[FZ] = 1'b1;
      end
      CTL_JN: if (flags_i[FN]) begin
        taken_o   = 1'b1;
        target_o  = reg_pc;
        clr_o[FN] = 1'b1;
      end
      CTL_JC: if (flags_i[FC]) begin
        taken_o   = 1'b1;
        target_o  = reg_pc;
        clr_o[FC] = 1'b1;
      end
      CTL_JMP: begin
        taken_o  = 1'b1;
        target_o = reg_pc;
      end
      CTL_INT: begin
        taken_o  = 1'b1;
        target_o = vec_pc;
        int_o    = 1'b1;
      end
      CTL_RTI: restore_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfb_flag_reg.sv
module cfb_flag_reg
  import cfb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_upd_t upd_i,
  input  flags_t    clr_i,
  input  logic      restore_i,
  input  flags_t    saved_i,
  output flags_t    flags_o
);

  generate
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      logic bit_q;
      logic bit_d;
      logic bit_en;

      // restore wins over everything, a jump clear wins over the ALU value
      always_comb begin
        bit_en = restore_i | upd_i.mask[b] | clr_i[b];
        if (restore_i) begin
          bit_d = saved_i[b];
        end else if (clr_i[b]) begin
          bit_d = 1'b0;
        end else begin
          bit_d = upd_i.val[b];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_en) begin
          bit_q <= bit_d;
        end
      end

      assign flags_o[b] = bit_q;
    end
  endgenerate

endmodule

// File: rtl/cfb_unit.sv
module cfb_unit
  import cfb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 20,
  parameter int IMEM_AW  = 20,
  parameter int VEC_BASE = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         alu_cls,
  input  logic [DATA_W-1:0]  alu_res,
  input  logic               alu_cout,
  input  logic [2:0]         ctl_cls,
  input  logic [DATA_W-1:0]  jmp_reg,
  input  logic               int_sel,
  input  logic [DATA_W-1:0]  vec_hi,
  input  logic [DATA_W-1:0]  vec_lo,
  input  logic [2:0]         saved_flags,
  output logic [2:0]         flags,
  output logic               br_taken,
  output logic [PC_W-1:0]    br_target,
  output logic [IMEM_AW-1:0] int_vec_addr,
  output logic [2:0]         int_save_flags
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe_q;
  logic [SYNC_N-1:0] rst_pipe_d;
  logic              rst_n_sync;

  flag_upd_t alu_upd;
  flags_t    jmp_clr;
  flags_t    flags_q;
  logic      rti_hit;
  logic      int_hit;

  // reset synchronizer: asserts at once, releases after SYNC_N edges
  assign rst_pipe_d = {rst_pipe_q[SYNC_N-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_n_sync = rst_pipe_q[SYNC_N-1];

  cfb_alu_flags #(
    .DATA_W (DATA_W)
  ) u_alu_flags (
    .cls_i  (alu_cls),
    .res_i  (alu_res),
    .cout_i (alu_cout),
    .upd_o  (alu_upd)
  );

  cfb_branch #(
    .DATA_W   (DATA_W),
    .PC_W     (PC_W),
    .IMEM_AW  (IMEM_AW),
    .VEC_BASE (VEC_BASE)
  ) u_branch (
    .cls_i      (ctl_cls),
    .flags_i    (flags_q),
    .reg_i      (jmp_reg),
    .int_sel_i  (int_sel),
    .vec_hi_i   (vec_hi),
    .vec_lo_i   (vec_lo),
    .taken_o    (br_taken),
    .target_o   (br_target),
    .clr_o      (jmp_clr),
    .restore_o  (rti_hit),
    .int_o      (int_hit),
    .vec_addr_o (int_vec_addr)
  );

  cfb_flag_reg u_flag_reg (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .upd_i     (alu_upd),
    .clr_i     (jmp_clr),
    .restore_i (rti_hit),
    .saved_i   (saved_flags),
    .flags_o   (flags_q)
  );

  assign flags          = flags_q;
  assign int_save_flags = int_hit ? flags_q : '0;

endmodule

// File: rtl/cfb_unit_chk.sv
module cfb_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] alu_cls,
  input logic [2:0] ctl_cls,
  input logic [2:0] saved_flags,
  input logic [2:0] flags,
  input logic       br_taken,
  input logic [2:0] int_save_flags
);

  // R3
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_cls == 3'd2 && ctl_cls != 3'd6 && ctl_cls != 3'd3) |=> (flags[2] == $past(flags[2])));

  // R4
  setc_sets_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_cls == 3'd4 && ctl_cls != 3'd6 && ctl_cls != 3'd3) |=> flags[2]);

  // R5
  jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd1 && flags[0]) |-> br_taken);

  // R10
  jz_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd1 && flags[0]) |=> !flags[0]);

  // R6
  jc_untaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd3 && !flags[2]) |-> !br_taken);

  // R7
  jmp_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd4) |-> br_taken);

  // R8
  int_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd5) |-> (int_save_flags == flags));

  // R9
  rti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cls == 3'd6) |=> (flags == $past(saved_flags)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_cls == 3'd0 && ctl_cls == 3'd0) |=> $stable(flags));

endmodule

bind cfb_unit cfb_unit_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n_sync),
  .alu_cls        (alu_cls),
  .ctl_cls        (ctl_cls),
  .saved_flags    (saved_flags),
  .flags          (flags),
  .br_taken       (br_taken),
  .int_save_flags (int_save_flags)
);

// File: tb/cfb_unit_bench.sv
module cfb_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [2:0]  alu_cls;
  logic [15:0] alu_res;
  logic        alu_cout;
  logic [2:0]  ctl_cls;
  logic [15:0] jmp_reg;
  logic        int_sel;
  logic [15:0] vec_hi;
  logic [15:0] vec_lo;
  logic [2:0]  saved_flags;
  logic [2:0]  flags;
  logic        br_taken;
  logic [19:0] br_target;
  logic [19:0] int_vec_addr;
  logic [2:0]  int_save_flags;

  int n_chk;
  int n_bad;
  bit done;

  // combinational outputs captured just before the edge
  logic        s_taken;
  logic [19:0] s_target;
  logic [19:0] s_vaddr;
  logic [2:0]  s_save;

  cfb_unit u_cfb_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .alu_cls        (alu_cls),
    .alu_res        (alu_res),
    .alu_cout       (alu_cout),
    .ctl_cls        (ctl_cls),
    .jmp_reg        (jmp_reg),
    .int_sel        (int_sel),
    .vec_hi         (vec_hi),
    .vec_lo         (vec_lo),
    .saved_flags    (saved_flags),
    .flags          (flags),
    .br_taken       (br_taken),
    .br_target      (br_target),
    .int_vec_addr   (int_vec_addr),
    .int_save_flags (int_save_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    alu_cls = 3'd0; alu_res = '0; alu_cout = 1'b0;
    ctl_cls = 3'd0; jmp_reg = '0; int_sel = 1'b0;
    vec_hi = '0; vec_lo = '0; saved_flags = '0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input logic [2:0] a, input logic [15:0] r, input logic c,
                       input logic [2:0] k, input logic [15:0] j, input logic s,
                       input logic [15:0] h, input logic [15:0] l, input logic [2:0] sv);
    alu_cls = a; alu_res = r; alu_cout = c;
    ctl_cls = k; jmp_reg = j; int_sel = s;
    vec_hi = h; vec_lo = l; saved_flags = sv;
    #1;
    s_taken = br_taken; s_target = br_target;
    s_vaddr = int_vec_addr; s_save = int_save_flags;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic load_flags(input logic [2:0] f);
    apply(3'd0, 16'h0, 1'b0, 3'd6, 16'h0, 1'b0, 16'h0, 16'h0, f);
  endtask

  task automatic t_reset();
    chk("R1 flags", {29'b0, flags}, 32'h0);
    chk("R1 br_taken", {31'b0, br_taken}, 32'h0);
    chk("R1 br_target", {12'b0, br_target}, 32'h0);
    chk("R1 int_save_flags", {29'b0, int_save_flags}, 32'h0);
  endtask

  task automatic t_arith_shift();
    apply(3'd1, 16'h0000, 1'b1, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R2 arith zero+carry", {29'b0, flags}, 32'h5);
    apply(3'd1, 16'h8001, 1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R2 arith negative", {29'b0, flags}, 32'h2);
    apply(3'd1, 16'h0005, 1'b1, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R2 arith carry only", {29'b0, flags}, 32'h4);
    load_flags(3'b000);
    apply(3'd3, 16'hFFFF, 1'b1, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R2 shift", {29'b0, flags}, 32'h6);
  endtask

  task automatic t_logic();
    apply(3'd1, 16'h0001, 1'b1, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    apply(3'd2, 16'h0000, 1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R3 logic zero keeps C", {29'b0, flags}, 32'h5);
    apply(3'd2, 16'h8000, 1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R3 logic neg keeps C", {29'b0, flags}, 32'h6);
    load_flags(3'b001);
    apply(3'd2, 16'h0010, 1'b1, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R3 logic ignores cout", {29'b0, flags}, 32'h0);
  endtask

  task automatic t_setc();
    load_flags(3'b010);
    apply(3'd4, 16'h0000, 1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R4 setc keeps N", {29'b0, flags}, 32'h6);
    load_flags(3'b001);
    apply(3'd4, 16'h8000, 1'b0, 3'd0, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R4 setc keeps Z", {29'b0, flags}, 32'h5);
  endtask

  task automatic t_cond_jump();
    load_flags(3'b111);
    apply(3'd0, 16'h0, 1'b0, 3'd1, 16'hF00D, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R5 jz taken", {31'b0, s_taken}, 32'h1);
    chk("R5 jz target", {12'b0, s_target}, 32'h0F00D);
    chk("R5 jz clears Z", {29'b0, flags}, 32'h6);
    apply(3'd0, 16'h0, 1'b0, 3'd2, 16'h1234, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R5 jn taken", {31'b0, s_taken}, 32'h1);
    chk("R5 jn target", {12'b0, s_target}, 32'h01234);
    chk("R5 jn clears N", {29'b0, flags}, 32'h4);
    apply(3'd0, 16'h0, 1'b0, 3'd3, 16'h8000, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R5 jc taken", {31'b0, s_taken}, 32'h1);
    chk("R5 jc target", {12'b0, s_target}, 32'h08000);
    chk("R5 jc clears C", {29'b0, flags}, 32'h0);
    for (int k = 1; k <= 3; k++) begin
      apply(3'd0, 16'h0, 1'b0, 3'(k), 16'hBEEF, 1'b0, 16'h0, 16'h0, 3'd0);
      chk("R6 untaken", {31'b0, s_taken}, 32'h0);
      chk("R6 untaken target", {12'b0, s_target}, 32'h0);
      chk("R6 untaken flags", {29'b0, flags}, 32'h0);
    end
    load_flags(3'b110);
    apply(3'd0, 16'h0, 1'b0, 3'd1, 16'hBEEF, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R6 jz untaken others set", {31'b0, s_taken}, 32'h0);
    chk("R6 jz untaken flags", {29'b0, flags}, 32'h6);
  endtask

  task automatic t_jmp();
    load_flags(3'b101);
    apply(3'd0, 16'h0, 1'b0, 3'd4, 16'hA5A5, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R7 jmp taken", {31'b0, s_taken}, 32'h1);
    chk("R7 jmp target", {12'b0, s_target}, 32'h0A5A5);
    chk("R7 jmp flags", {29'b0, flags}, 32'h5);
  endtask

  task automatic t_int();
    load_flags(3'b011);
    apply(3'd0, 16'h0, 1'b0, 3'd5, 16'h0, 1'b0, 16'hABCD, 16'h1234, 3'd0);
    chk("R8 int taken", {31'b0, s_taken}, 32'h1);
    chk("R8 int vec addr 0", {12'b0, s_vaddr}, 32'h6);
    chk("R8 int target", {12'b0, s_target}, 32'hD1234);
    chk("R8 int save", {29'b0, s_save}, 32'h3);
    chk("R8 int flags", {29'b0, flags}, 32'h3);
    apply(3'd0, 16'h0, 1'b0, 3'd5, 16'h0, 1'b1, 16'h0001, 16'h8000, 3'd0);
    chk("R8 int vec addr 2", {12'b0, s_vaddr}, 32'h8);
    chk("R8 int target 2", {12'b0, s_target}, 32'h18000);
    apply(3'd0, 16'h0, 1'b0, 3'd4, 16'h0, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R8 save zero outside", {29'b0, s_save}, 32'h0);
  endtask

  task automatic t_rti();
    load_flags(3'b000);
    apply(3'd1, 16'h0007, 1'b0, 3'd6, 16'h0, 1'b0, 16'h0, 16'h0, 3'b101);
    chk("R9 rti no branch", {31'b0, s_taken}, 32'h0);
    chk("R9 rti overrides alu", {29'b0, flags}, 32'h5);
  endtask

  task automatic t_prec();
    load_flags(3'b001);
    apply(3'd1, 16'h0000, 1'b1, 3'd1, 16'h0042, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R10 jz+arith taken", {31'b0, s_taken}, 32'h1);
    chk("R10 jz+arith flags", {29'b0, flags}, 32'h4);
    load_flags(3'b100);
    apply(3'd4, 16'h0, 1'b0, 3'd3, 16'h0042, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R10 jc+setc flags", {29'b0, flags}, 32'h0);
    load_flags(3'b010);
    apply(3'd2, 16'h8000, 1'b0, 3'd2, 16'h0042, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R10 jn+logic flags", {29'b0, flags}, 32'h0);
  endtask

  task automatic t_ignored();
    load_flags(3'b111);
    apply(3'd0, 16'h0000, 1'b0, 3'd0, 16'h1111, 1'b0, 16'h0, 16'h0, 3'd0);
    chk("R11 idle taken", {31'b0, s_taken}, 32'h0);
    chk("R11 idle flags", {29'b0, flags}, 32'h7);
    for (int a = 5; a <= 7; a++) begin
      apply(3'(a), 16'h0001, 1'b0, 3'd7, 16'h2222, 1'b1, 16'h0, 16'h0, 3'd0);
      chk("R11 unused codes taken", {31'b0, s_taken}, 32'h0);
      chk("R11 unused codes flags", {29'b0, flags}, 32'h7);
    end
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_arith_shift();
    t_logic();
    t_setc();
    t_cond_jump();
    t_jmp();
    t_int();
    t_rti();
    t_prec();
    t_ignored();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule